// File: doc/BRIEF.md
# Serial Port Register Unit

This block is the bus-side front end of a simple byte-oriented serial port. A processor reaches eight byte-wide registers, each on its own 32-bit word. Through them it reads four fixed identification bytes and programs a 16-bit baud divisor. It moves characters through a single data register and controls and inspects the port through one combined status/control register. The line-timing engines sit outside this block. The receive engine hands characters in over a valid/ready stream, and the transmit engine takes them out over a second valid/ready stream.

Received characters wait in a four-entry FIFO until software reads them. Outgoing characters use a single holding register. Software clears the two receive error flags, frame and overrun, by writing zero to them. The same register holds the two interrupt enables. One interrupt line covers both directions. It asserts when receive interrupts are enabled and there is data or an error to service. It also asserts when transmit interrupts are enabled and the holding register is free.

The receive stream never pushes back: `rx_ready` is always high, and a character offered while the FIFO is full is dropped and recorded as an overrun. The transmit stream holds `tx_valid` and `tx_data` steady until the engine raises `tx_ready`. The byte is handed over on the first clock edge where both are high.

Top module: `uart_csr_unit`

## Requirements
- R1: After reset, STATUS reads 0xA0 (transmit empty and receive empty set, everything else clear), `irq` and `tx_valid` are low, and the divisor output is 0.
- R2: The register slot is chosen by `bus_addr[4:2]`, and `bus_addr[1:0]` is ignored. Slots 0..3 (byte addresses 0x00, 0x04, 0x08, 0x0C) read byte 0..3 of parameter ID_WORD, least significant byte first. Slot 6 (0x18) holds the divisor low byte and slot 7 (0x1C) the high byte; both are readable and are exported as `baud_div = {high, low}`.
- R3: STATUS (slot 5, 0x14) bits are: 0 frame error, 1 overrun, 2 receive interrupt enable, 3 FIFO full, 4 exactly one free FIFO slot, 5 FIFO empty, 6 transmit interrupt enable, 7 transmit holding register empty.
- R4: A character accepted on the receive stream enters a 4-entry FIFO. A read of DATA (slot 4, 0x10) returns the oldest entry and removes it at that clock edge; order is first in, first out.
- R5: A DATA read while the FIFO is empty returns the most recently removed character (0 if none since reset) and leaves the FIFO state unchanged.
- R6: `rx_ready` is always 1. A character that arrives while the FIFO holds 4 entries is discarded and sets the overrun flag, even if a DATA read happens in the same cycle.
- R7: A character that arrives with `rx_frame_err` high sets the frame error flag. The character itself is still stored if there is room.
- R8: Writing STATUS with bit 0 or bit 1 at 0 clears that error flag, and writing 1 leaves it unchanged. If a new error arrives in the same cycle as a clearing write, the flag ends up set.
- R9: A STATUS write stores only bits 2 and 6. Bits 3, 4, 5 and 7 of the write data have no effect.
- R10: A DATA write while the holding register is empty loads it: `tx_valid` rises and STATUS bit 7 falls on the next cycle. Both stay that way, with `tx_data` stable, until a cycle with `tx_valid` and `tx_ready` both high. A DATA write while the register is full is dropped.
- R11: `irq` equals (receive enable AND (FIFO not empty OR frame error OR overrun)) OR (transmit enable AND holding register empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] pick the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| rx_valid | input | 1 | Receive engine offers a character |
| rx_ready | output | 1 | Always 1; overflow is handled by dropping |
| rx_data | input | 8 | Received character |
| rx_frame_err | input | 1 | Stop bit missing on this character |
| tx_valid | output | 1 | Holding register has a character for the transmit engine |
| tx_ready | input | 1 | Transmit engine takes the character |
| tx_data | output | 8 | Character to transmit |
| irq | output | 1 | Combined receive/transmit interrupt |
| baud_div | output | 16 | Programmed baud divisor |

## Verification
The properties assume that the transmit engine may hold off `tx_ready` for any length of time. They also assume the receive engine may offer characters on back-to-back cycles whatever the FIFO occupancy, so overrun and simultaneous read-and-arrive cases are legal inputs. The stimulus covers these cases directly. Directed phases fill the FIFO past capacity, stall the transmit side while software writes again, and collide error clearing with fresh errors. A long pseudo-random phase then mixes every access type with random stream activity.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [2:0] {
    SLOT_ID0  = 3'd0,
    SLOT_ID1  = 3'd1,
    SLOT_ID2  = 3'd2,
    SLOT_ID3  = 3'd3,
    SLOT_DATA = 3'd4,
    SLOT_STAT = 3'd5,
    SLOT_DIVL = 3'd6,
    SLOT_DIVH = 3'd7
  } slot_e;

  localparam int ST_FERR  = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_RXIE  = 2;
  localparam int ST_FULL  = 3;
  localparam int ST_ONE   = 4;
  localparam int ST_EMPTY = 5;
  localparam int ST_TXIE  = 6;
  localparam int ST_TXE   = 7;
endpackage

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PW'(i)) mem[i] <= din;
    end
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data
);
  logic          full_q;
  logic [DW-1:0] byte_q;

  assign tx_valid = full_q;
  assign tx_data  = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      byte_q <= '0;
    end else if (!full_q) begin
      if (load) begin
        full_q <= 1'b1;
        byte_q <= din;
      end
    end else if (tx_ready) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_csr_unit.sv
module uart_csr_unit
  import sio_pkg::*;
#(
  parameter int          DEPTH   = 4,
  parameter int          ADDR_W  = 5,
  parameter logic [31:0] ID_WORD = 32'h5A_01_C3_17,
  localparam int         DW      = 8,
  localparam int         DIV_W   = 2 * DW,
  localparam int         CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_frame_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DW-1:0]     tx_data,
  output logic              irq,
  output logic [DIV_W-1:0]  baud_div
);
  slot_e         slot;
  logic          hi_zero;
  logic          wr_data, wr_stat, wr_divl, wr_divh, rd_data;
  logic [DW-1:0] rxq_head, last_rd, div_lo, div_hi;
  logic [CW-1:0] rxq_count;
  logic          rxq_empty, rxq_full, rxq_one;
  logic          push, pop;
  logic          ferr_q, ovr_q, rx_ie_q, tx_ie_q;
  logic [DW-1:0] status;

  if (ADDR_W > 5) begin : g_hi
    assign hi_zero = ~|bus_addr[ADDR_W-1:5];
  end else begin : g_nohi
    assign hi_zero = 1'b1;
  end

  assign slot    = slot_e'(bus_addr[4:2]);
  assign wr_data = bus_sel && bus_wr && hi_zero && slot == SLOT_DATA;
  assign wr_stat = bus_sel && bus_wr && hi_zero && slot == SLOT_STAT;
  assign wr_divl = bus_sel && bus_wr && hi_zero && slot == SLOT_DIVL;
  assign wr_divh = bus_sel && bus_wr && hi_zero && slot == SLOT_DIVH;
  assign rd_data = bus_sel && !bus_wr && hi_zero && slot == SLOT_DATA;

  assign rxq_empty = rxq_count == '0;
  assign rxq_full  = rxq_count == CW'(DEPTH);
  assign rxq_one   = rxq_count == CW'(DEPTH - 1);
  assign rx_ready  = 1'b1;
  assign push      = rx_valid && !rxq_full;
  assign pop       = rd_data && !rxq_empty;

  sio_rx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .din(rx_data), .head(rxq_head), .count(rxq_count)
  );

  sio_tx_hold #(.DW(DW)) u_txh (
    .clk(clk), .rst_n(rst_n), .load(wr_data), .din(bus_wdata),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
      rx_ie_q <= 1'b0;
      tx_ie_q <= 1'b0;
      last_rd <= '0;
      div_lo  <= '0;
      div_hi  <= '0;
    end else begin
      ferr_q <= (rx_valid && rx_frame_err) ||
                (ferr_q && !(wr_stat && !bus_wdata[ST_FERR]));
      ovr_q  <= (rx_valid && rxq_full) ||
                (ovr_q && !(wr_stat && !bus_wdata[ST_OVR]));
      if (wr_stat) begin
        rx_ie_q <= bus_wdata[ST_RXIE];
        tx_ie_q <= bus_wdata[ST_TXIE];
      end
      if (pop)     last_rd <= rxq_head;
      if (wr_divl) div_lo  <= bus_wdata;
      if (wr_divh) div_hi  <= bus_wdata;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_FERR]  = ferr_q;
    status[ST_OVR]   = ovr_q;
    status[ST_RXIE]  = rx_ie_q;
    status[ST_FULL]  = rxq_full;
    status[ST_ONE]   = rxq_one;
    status[ST_EMPTY] = rxq_empty;
    status[ST_TXIE]  = tx_ie_q;
    status[ST_TXE]   = !tx_valid;
  end

  always_comb begin
    bus_rdata = '0;
    if (hi_zero) begin
      unique case (slot)
        SLOT_ID0:  bus_rdata = ID_WORD[7:0];
        SLOT_ID1:  bus_rdata = ID_WORD[15:8];
        SLOT_ID2:  bus_rdata = ID_WORD[23:16];
        SLOT_ID3:  bus_rdata = ID_WORD[31:24];
        SLOT_DATA: bus_rdata = rxq_empty ? last_rd : rxq_head;
        SLOT_STAT: bus_rdata = status;
        SLOT_DIVL: bus_rdata = div_lo;
        SLOT_DIVH: bus_rdata = div_hi;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign irq      = (rx_ie_q && (!rxq_empty || ferr_q || ovr_q)) ||
                    (tx_ie_q && !tx_valid);
  assign baud_div = {div_hi, div_lo};
endmodule

// File: rtl/uart_csr_unit_chk.sv
module uart_csr_unit_chk #(
  parameter int  DEPTH  = 4,
  parameter int  ADDR_W = 5,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              irq,
  input logic [CW-1:0]     fifo_cnt,
  input logic              ovr_q,
  input logic              rx_ie_q,
  input logic              tx_ie_q
);
  logic sts_wr;
  assign sts_wr = bus_sel && bus_wr && bus_addr[4:2] == 3'd5;

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && fifo_cnt == CW'(DEPTH) |=> ovr_q);

  // R8
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !sts_wr |=> ovr_q);

  // R9
  ie_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr |=> $stable(rx_ie_q) && $stable(tx_ie_q));

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie_q && !tx_ie_q |-> !irq);
endmodule

bind uart_csr_unit uart_csr_unit_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .rx_valid(rx_valid), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .irq(irq),
  .fifo_cnt(rxq_count), .ovr_q(ovr_q), .rx_ie_q(rx_ie_q), .tx_ie_q(tx_ie_q)
);

// File: tb/uart_csr_unit_test.sv
module uart_csr_unit_test;
  localparam int          DEPTH = 4;
  localparam logic [31:0] IDW   = 32'h5A_01_C3_17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        rx_valid = 0, rx_ready, rx_frame_err = 0;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, tx_ready = 0;
  logic [7:0]  tx_data;
  logic        irq;
  logic [15:0] baud_div;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_csr_unit #(.DEPTH(DEPTH), .ID_WORD(IDW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .irq(irq), .baud_div(baud_div)
  );

  // behavioural reference state
  byte unsigned q[$];
  logic [7:0] last_m = 0, txb_m = 0, divl_m = 0, divh_m = 0;
  bit ferr_m = 0, ovr_m = 0, rxie_m = 0, txie_m = 0, txf_m = 0;

  function automatic logic [7:0] exp_status();
    return {~txf_m, txie_m, q.size() == 0, q.size() == DEPTH - 1,
            q.size() == DEPTH, rxie_m, ovr_m, ferr_m};
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [4:0] a);
    case (a[4:2])
      3'd0, 3'd1, 3'd2, 3'd3: return IDW >> (8 * a[4:2]);
      3'd4: return (q.size() == 0) ? last_m : q[0];
      3'd5: return exp_status();
      3'd6: return divl_m;
      default: return divh_m;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [7:0] er;
    bit ei;
    er = exp_rdata(bus_addr);
    ei = (rxie_m && (q.size() != 0 || ferr_m || ovr_m)) || (txie_m && !txf_m);
    chk(bus_rdata === er, tag, "rdata", bus_rdata, er);
    chk(irq === ei, "R11", "irq", irq, ei);
    chk(tx_valid === txf_m, "R10", "tx_valid", tx_valid, txf_m);
    if (txf_m) chk(tx_data === txb_m, "R10", "tx_data", tx_data, txb_m);
    chk(baud_div === {divh_m, divl_m}, "R2", "baud_div", baud_div, {divh_m, divl_m});
    chk(rx_ready === 1'b1, "R6", "rx_ready", rx_ready, 1);
  endtask

  task automatic update_model();
    bit wr_st, full_now, pop;
    full_now = q.size() == DEPTH;
    wr_st = bus_sel && bus_wr && bus_addr[4:2] == 3'd5;
    pop = bus_sel && !bus_wr && bus_addr[4:2] == 3'd4 && q.size() != 0;
    ferr_m = (rx_valid && rx_frame_err) || (ferr_m && !(wr_st && !bus_wdata[0]));
    ovr_m  = (rx_valid && full_now) || (ovr_m && !(wr_st && !bus_wdata[1]));
    if (wr_st) begin
      rxie_m = bus_wdata[2];
      txie_m = bus_wdata[6];
    end
    if (pop) last_m = q.pop_front();
    if (rx_valid && !full_now) q.push_back(rx_data);
    if (txf_m) begin
      if (tx_ready) txf_m = 0;
    end else if (bus_sel && bus_wr && bus_addr[4:2] == 3'd4) begin
      txf_m = 1;
      txb_m = bus_wdata;
    end
    if (bus_sel && bus_wr && bus_addr[4:2] == 3'd6) divl_m = bus_wdata;
    if (bus_sel && bus_wr && bus_addr[4:2] == 3'd7) divh_m = bus_wdata;
  endtask

  task automatic cyc(input string tag, input bit sel, input bit wr,
                     input logic [4:0] a, input logic [7:0] wd,
                     input bit rv, input bit fe, input logic [7:0] rd,
                     input bit tr);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rx_valid = rv; rx_frame_err = fe; rx_data = rd; tx_ready = tr;
    #1 compare(tag);
    @(posedge clk);
    update_model();
    @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic [4:0] a);
    cyc(tag, 1, 0, a, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(input string tag, input logic [4:0] a, input logic [7:0] d);
    cyc(tag, 1, 1, a, d, 0, 0, 0, 0);
  endtask
  task automatic rx(input string tag, input logic [7:0] d, input bit fe);
    cyc(tag, 0, 0, 5'h14, 0, 1, fe, d, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    bus_addr = 5'h14;
    #1;
    chk(bus_rdata === 8'hA0, "R1", "status after reset", bus_rdata, 8'hA0);
    chk(irq === 1'b0 && tx_valid === 1'b0 && baud_div === 16'h0, "R1",
        "irq/tx_valid/div", {irq, tx_valid, baud_div}, 0);
    @(negedge clk);
    rd("R1", 5'h10);
    // R2: map, ID bytes, divisor, low-bit aliasing
    for (int i = 0; i < 8; i++) rd("R2", 5'(i * 4));
    wr("R2", 5'h18, 8'h34);
    wr("R2", 5'h1F, 8'h12);
    rd("R2", 5'h19);
    rd("R2", 5'h1C);
    // R9: only enables stored
    wr("R9", 5'h14, 8'hFF);
    rd("R9", 5'h14);
    wr("R9", 5'h14, 8'hBB);
    rd("R9", 5'h14);
    wr("R9", 5'h14, 8'h00);
    // R4: FIFO order
    rx("R4", 8'h11, 0); rx("R4", 8'h22, 0); rx("R4", 8'h33, 0);
    rd("R3", 5'h14);
    for (int i = 0; i < 3; i++) rd("R4", 5'h10);
    // R5: empty reads
    rd("R5", 5'h10); rd("R5", 5'h10); rd("R5", 5'h14);
    // R6: overrun
    for (int i = 0; i < 6; i++) rx("R6", 8'(8'h40 + i), 0);
    rd("R6", 5'h14);
    cyc("R6", 1, 0, 5'h10, 0, 1, 0, 8'h77, 0);
    for (int i = 0; i < 4; i++) rd("R6", 5'h10);
    // R7: frame error with stored char
    rx("R7", 8'h5C, 1);
    rd("R7", 5'h14); rd("R7", 5'h10);
    // R8: clearing rules
    wr("R8", 5'h14, 8'h03); rd("R8", 5'h14);
    wr("R8", 5'h14, 8'h02); rd("R8", 5'h14);
    cyc("R8", 1, 1, 5'h14, 8'h00, 1, 1, 8'h66, 0);
    rd("R8", 5'h14);
    wr("R8", 5'h14, 8'h00); rd("R8", 5'h14); rd("R8", 5'h10);
    // R10: transmit holding
    wr("R10", 5'h10, 8'hA5);
    rd("R10", 5'h14);
    wr("R10", 5'h10, 8'h5A);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 1);
    rd("R10", 5'h14);
    // R11: interrupt sources
    wr("R11", 5'h14, 8'h44);
    rx("R11", 8'h99, 0);
    rd("R11", 5'h10);
    wr("R11", 5'h10, 8'h01);
    cyc("R11", 0, 0, 0, 0, 0, 0, 0, 1);
    wr("R11", 5'h14, 8'h00);
    // mixed pseudo-random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc("R4", r[0], r[1] & r[2], {r[5:3], r[7:6]}, r[15:8],
          r[16] & r[17], r[18] & r[19] & r[20], r[28:21], r[29]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule